// File: doc/BRIEF.md
# Receive Buffer Credit Flow-Control Monitor

This block keeps a running count of the free receive buffers that software has handed to each receive DMA channel. It drives a backpressure flag toward the upstream packet source. Each monitor unit serves one pair of channels, the even-numbered receive channel and its odd-numbered transmit partner. Only the receive side takes part in flow control. Software grants buffers by writing a count to the unit's allocation register. The DMA channel pulses a consume strobe each time it fills a buffer. The unit compares its credit count against a programmable low and high threshold, with hysteresis between them.

A write with the top data bit set switches a unit into forced mode. In forced mode backpressure is withheld whatever the credit count is. Software uses this while a channel is shut down. A global control register gates the whole controller and each unit separately. A channel reset register holds one bit per channel. Setting a receive channel's bit wipes its unit's credits.

Top module: `rx_credit_flowctl`

## Requirements
- R1: After reset every credit count is 0 and every backpressure output is 0.
- R2: A write to a unit's allocation register (address 3u+3) with bit 31 clear adds the value in bits 30:0 to the credit count, visible on the next clock edge. The count saturates at 2^CNT_W-1.
- R3: Each cycle with a unit's consume strobe high lowers its credit count by one, and the count never goes below zero.
- R4: An allocation write and a consume strobe in the same cycle give a net change of N-1, with saturation applied to the net result.
- R5: While a unit is active, backpressure rises when the updated credit count is below the low threshold (address 3u+1).
- R6: Once raised, backpressure stays high while the credit count lies from the low up to below the high threshold (address 3u+2). It drops when the count reaches the high threshold. A count between the thresholds never raises it.
- R7: Backpressure is 0 one edge after the global control register (address 0) has bit 0 clear, or has bit u+1 clear for unit u.
- R8: An allocation write with bit 31 set puts the unit in forced mode. The count bits are ignored and the credit count is unchanged, and backpressure is held at 0. The next allocation write with bit 31 clear leaves forced mode.
- R9: The channel reset register (address 3·NUM_UNITS+1) holds bit c for channel c. While bit 2u is set, unit u's credits are held at 0 and its backpressure at 0. Odd bits have no effect.
- R10: Register writes and consume strobes for one unit leave every other unit's credits and backpressure unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(3·NUM_UNITS+2) | Register word address |
| cfg_wdata | input | DATA_W | Register write data |
| buf_take | input | NUM_UNITS | Per-unit buffer-consumed strobe from the receive channel |
| backpressure | output | NUM_UNITS | Per-unit registered backpressure flag |
| credit_lvl | output | NUM_UNITS·CNT_W | Per-unit registered free-credit count, unit u at bits u·CNT_W upward |

## Verification
The bench builds the block with NUM_UNITS=2 and CNT_W=4. A 4-bit count makes ceiling saturation reachable with a single grant of 15. Two units are the fewest that let the bench check isolation between units. They also let it check that an odd channel reset bit does not reach the next unit's even bit. Thresholds of 4 and 8 keep every hysteresis edge within a few consume strobes: fall through the low mark, hold between the marks, release at the high mark.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  // Register word offsets inside one unit's three-word window
  localparam int UNIT_WIN      = 3;
  localparam int OFS_LOW       = 1;
  localparam int OFS_HIGH      = 2;
  localparam int OFS_ALLOC     = 3;
  localparam int CTRL_ADDR     = 0;

  function automatic int rst_reg_addr(input int n_units);
    return UNIT_WIN * n_units + 1;
  endfunction
endpackage

// File: rtl/rxfc_regs.sv
module rxfc_regs
  import rxfc_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_UNITS-1:0]              unit_en,
  output logic [NUM_UNITS-1:0]              unit_clr,
  output logic [NUM_UNITS-1:0][CNT_W-1:0]   low_thr,
  output logic [NUM_UNITS-1:0][CNT_W-1:0]   high_thr,
  output logic [NUM_UNITS-1:0]              alloc_hit,
  output logic                              alloc_force,
  output logic [DATA_W-2:0]                 alloc_amt
);
  localparam logic [ADDR_W-1:0] RST_ADDR = ADDR_W'(rst_reg_addr(NUM_UNITS));

  logic [NUM_UNITS:0]   ctrl_q;
  logic [NUM_UNITS-1:0] clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      clr_q  <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= wdata[NUM_UNITS:0];
      if (addr == RST_ADDR) begin
        for (int u = 0; u < NUM_UNITS; u++) clr_q[u] <= wdata[2*u];
      end
    end
  end

  assign unit_en     = ctrl_q[0] ? ctrl_q[NUM_UNITS:1] : '0;
  assign unit_clr    = clr_q;
  assign alloc_force = wdata[DATA_W-1];
  assign alloc_amt   = wdata[DATA_W-2:0];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit_regs
    localparam logic [ADDR_W-1:0] A_LOW   = ADDR_W'(UNIT_WIN*u + OFS_LOW);
    localparam logic [ADDR_W-1:0] A_HIGH  = ADDR_W'(UNIT_WIN*u + OFS_HIGH);
    localparam logic [ADDR_W-1:0] A_ALLOC = ADDR_W'(UNIT_WIN*u + OFS_ALLOC);

    always_ff @(posedge clk) begin
      if (rst) begin
        low_thr[u]  <= '0;
        high_thr[u] <= '0;
      end else if (we) begin
        if (addr == A_LOW)  low_thr[u]  <= wdata[CNT_W-1:0];
        if (addr == A_HIGH) high_thr[u] <= wdata[CNT_W-1:0];
      end
    end

    assign alloc_hit[u] = we && (addr == A_ALLOC);
  end
endmodule

// File: rtl/rxfc_unit.sv
module rxfc_unit #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic              alloc_hit,
  input  logic              alloc_force,
  input  logic [DATA_W-2:0] alloc_amt,
  input  logic              take,
  input  logic [CNT_W-1:0]  low_thr,
  input  logic [CNT_W-1:0]  high_thr,
  output logic              bp,
  output logic [CNT_W-1:0]  credits
);
  localparam logic [DATA_W-1:0] MAXV = {{(DATA_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  logic              force_q;
  logic              active;
  logic [DATA_W-1:0] wide;
  logic [CNT_W-1:0]  nxt;
  logic              bp_nxt;

  assign active = en && !force_q;

  always_comb begin
    wide = {{(DATA_W-CNT_W){1'b0}}, credits};
    if (alloc_hit && !alloc_force) wide = wide + {1'b0, alloc_amt};
    if (take && wide != '0)        wide = wide - 1'b1;
    nxt = (wide > MAXV) ? {CNT_W{1'b1}} : wide[CNT_W-1:0];
    if (clr) nxt = '0;
  end

  always_comb begin
    bp_nxt = bp;
    if (clr || !active)        bp_nxt = 1'b0;
    else if (nxt < low_thr)    bp_nxt = 1'b1;
    else if (nxt >= high_thr)  bp_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credits <= '0;
      bp      <= 1'b0;
      force_q <= 1'b0;
    end else begin
      credits <= nxt;
      bp      <= bp_nxt;
      if (alloc_hit) force_q <= alloc_force;
    end
  end

  p_take_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (take && !alloc_hit && !clr && credits != '0) |=> credits == $past(credits) - 1'b1);
  p_take_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (take && !alloc_hit && !clr && credits == '0) |=> credits == '0);
  p_grant_grows_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_hit && !alloc_force && !take && !clr) |=> credits >= $past(credits));
  p_rise_below_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bp) |-> credits < $past(low_thr));
  p_release_at_high_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(bp) && $past(active) && !$past(clr)) |-> credits >= $past(high_thr));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !active |=> !bp);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (credits == '0 && !bp));
endmodule

// File: rtl/rx_credit_flowctl.sv
module rx_credit_flowctl #(
  parameter int NUM_UNITS = 8,
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [$clog2(3*NUM_UNITS+2)-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]                  cfg_wdata,
  input  logic [NUM_UNITS-1:0]               buf_take,
  output logic [NUM_UNITS-1:0]               backpressure,
  output logic [NUM_UNITS*CNT_W-1:0]         credit_lvl
);
  localparam int ADDR_W = $clog2(3*NUM_UNITS+2);

  logic [NUM_UNITS-1:0]            unit_en;
  logic [NUM_UNITS-1:0]            unit_clr;
  logic [NUM_UNITS-1:0][CNT_W-1:0] low_thr;
  logic [NUM_UNITS-1:0][CNT_W-1:0] high_thr;
  logic [NUM_UNITS-1:0]            alloc_hit;
  logic                            alloc_force;
  logic [DATA_W-2:0]               alloc_amt;

  rxfc_regs #(
    .NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .unit_en(unit_en), .unit_clr(unit_clr), .low_thr(low_thr), .high_thr(high_thr),
    .alloc_hit(alloc_hit), .alloc_force(alloc_force), .alloc_amt(alloc_amt)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    rxfc_unit #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_unit (
      .clk(clk), .rst(rst), .en(unit_en[u]), .clr(unit_clr[u]),
      .alloc_hit(alloc_hit[u]), .alloc_force(alloc_force), .alloc_amt(alloc_amt),
      .take(buf_take[u]), .low_thr(low_thr[u]), .high_thr(high_thr[u]),
      .bp(backpressure[u]), .credits(credit_lvl[u*CNT_W +: CNT_W])
    );
  end

  // One strobe per allocation write reaches at most one unit (R10)
  p_one_grant_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_hit));
endmodule

// File: tb/rx_credit_flowctl_bench.sv
module rx_credit_flowctl_bench;
  localparam int NU = 2;
  localparam int CW = 4;
  localparam int DW = 32;
  localparam int AW = $clog2(3*NU+2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [NU-1:0] buf_take = '0;
  logic [NU-1:0] backpressure;
  logic [NU*CW-1:0] credit_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_credit_flowctl #(.NUM_UNITS(NU), .CNT_W(CW), .DATA_W(DW)) u_rx_credit_flowctl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .buf_take(buf_take), .backpressure(backpressure), .credit_lvl(credit_lvl)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_unit(input string req, input int u, input int exp_cr, input int exp_bp);
    chk(req, $sformatf("credits[%0d]", u), int'(credit_lvl[u*CW +: CW]), exp_cr);
    chk(req, $sformatf("bp[%0d]", u), int'(backpressure[u]), exp_bp);
  endtask

  // Drive at a falling edge; return after two further rising edges
  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic take_n(input int u, input int n);
    @(negedge clk);
    buf_take[u] = 1'b1;
    repeat (n) @(negedge clk);
    buf_take[u] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_unit("R1", 0, 0, 0);
    chk_unit("R1", 1, 0, 0);
  endtask

  task automatic t_enable_low;
    wr(0, 32'h7);          // master + both units
    wr(1, 32'd4);          // unit0 low
    wr(2, 32'd8);          // unit0 high
    chk_unit("R5", 0, 0, 1);
    chk_unit("R10", 1, 0, 0);
  endtask

  task automatic t_hysteresis;
    wr(3, 32'd5);  chk_unit("R2", 0, 5, 1);   // between marks: hold high (R6)
    wr(3, 32'd3);  chk_unit("R6", 0, 8, 0);   // reaches high mark
    take_n(0, 3);  chk_unit("R3", 0, 5, 0);   // between: stays low (R6)
    take_n(0, 1);  chk_unit("R6", 0, 4, 0);
    take_n(0, 1);  chk_unit("R5", 0, 3, 1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(3); cfg_wdata = 32'd6; buf_take[0] = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; buf_take[0] = 1'b0;
    @(negedge clk);
    chk_unit("R4", 0, 8, 0);
  endtask

  task automatic t_saturate;
    wr(3, 32'd15); chk_unit("R2", 0, 15, 0);
    take_n(0, 20); chk_unit("R3", 0, 0, 1);
  endtask

  task automatic t_force;
    wr(3, 32'h8000_0005);
    chk_unit("R8", 0, 0, 0);
    wr(3, 32'd2);
    chk_unit("R8", 0, 2, 1);
  endtask

  task automatic t_gating;
    wr(0, 32'h5); chk("R7", "bp[0] unit off", int'(backpressure[0]), 0);
    wr(0, 32'h6); chk("R7", "bp[0] master off", int'(backpressure[0]), 0);
    wr(0, 32'h7); chk("R7", "bp[0] re-enabled", int'(backpressure[0]), 1);
  endtask

  task automatic t_isolation;
    wr(6, 32'd7);
    chk_unit("R10", 1, 7, 0);
    chk_unit("R10", 0, 2, 1);
    wr(4, 32'd10);
    wr(5, 32'd12);
    chk_unit("R10", 1, 7, 1);
    chk_unit("R10", 0, 2, 1);
  endtask

  task automatic t_chan_reset;
    wr(7, 32'h2);  // odd channel 1 bit: no effect
    chk_unit("R9", 0, 2, 1);
    chk_unit("R9", 1, 7, 1);
    wr(7, 32'h1);  // receive channel 0
    chk_unit("R9", 0, 0, 0);
    chk_unit("R9", 1, 7, 1);
    wr(3, 32'd9);  // held clear ignores grants
    chk_unit("R9", 0, 0, 0);
    wr(7, 32'h0);
    chk_unit("R9", 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_low();
    t_hysteresis();
    t_same_cycle();
    t_saturate();
    t_force();
    t_gating();
    t_isolation();
    t_chan_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule